// File: doc/BRIEF.md
# SD Command-Line Error Detector

This block sits beside the command-path transmitter of an SD host. It follows each command bit by bit at the SDCLK rate, which is given as a one-cycle enable on the system clock. While the host drives the line it compares every 1 it puts out with the level read back one SDCLK tick later. If the line reads 0 instead, the block withdraws the output enable at once, so the host stops driving a line that another agent is pulling low.

After the command's end bit the line is released. If a response is expected, the block waits for a start bit within a fixed window and then gathers a 48-bit response. It checks that response for a bad CRC7, a 0 end bit and an index that does not match the issued command.

Errors are collected in a four-bit status register, and software clears each bit by writing 1 to it. Together, the timeout and CRC bits tell the four outcomes of a command apart: no error, no response, a corrupted response, or a line conflict.

Top module: `sd_cmd_err_det`

## Requirements
- R1: After a synchronous reset, `status` is 4'b0000 and `cmd_oe` is 0.
- R2: Status bit 0 is response timeout, bit 1 is CRC error, bit 2 is end-bit error and bit 3 is index error. A one-cycle `clr_we` clears every set bit whose `clr_mask` bit is 1 and leaves the bits whose mask bit is 0 unchanged.
- R3: If a clear and a new error for the same bit fall in the same cycle, the bit ends up set.
- R4: The release tick is the first SDCLK tick on which `tx_drive` is low after a command. When a response is expected, bit 0 is set on the 64th tick after the release tick if no 0 start bit was seen on ticks 1 to 64. A start bit seen on tick 64 is accepted as a response.
- R5: While `tx_drive` is high, if the host drove a 1 on one tick and `cmd_line` is 0 on the next tick, `cmd_oe` is 0 from the cycle after that tick and stays 0 until `tx_drive` goes low.
- R6: A line conflict sets bits 1 and 0 together (status[1:0] = 2'b11) on the conflict tick, without waiting for the timeout window. No response is then awaited for that command.
- R7: A response whose received CRC differs from the CRC7 (x^7+x^3+1, register cleared to 0, MSB-first) of its first 40 bits sets bit 1 only (status[1:0] = 2'b10).
- R8: A response whose 48th bit is sampled as 0 sets bit 2.
- R9: A response whose bits 2 to 7 (6-bit index, MSB first) differ from the `cmd_index` latched at the first driven tick of the command sets bit 3.
- R10: A correct response (start 0, direction 0, matching index, 32-bit argument, correct CRC, end bit 1) sets no status bit.
- R11: When `resp_expected` was low at the first driven tick, no timeout, CRC, end-bit or index error is raised for that command, whatever the line does afterwards.
- R12: Without a conflict, `cmd_oe` equals `tx_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_tick | input | 1 | One-cycle enable marking each SDCLK edge |
| tx_drive | input | 1 | Transmitter wants to drive the command line |
| tx_bit | input | 1 | Bit the transmitter presents on this tick |
| cmd_line | input | 1 | Sampled level of the command line |
| cmd_index | input | 6 | Index of the command being issued |
| resp_expected | input | 1 | The command being issued expects a short response |
| clr_we | input | 1 | Write strobe for clearing status bits |
| clr_mask | input | 4 | Bits to clear when `clr_we` is high |
| status | output | 4 | Error status: {index, end bit, CRC, timeout} |
| cmd_oe | output | 1 | Output enable for the command-line driver |

## Verification
Some properties are checked on every cycle by the assertions. A status bit that is not being cleared never drops. `cmd_oe` is never high without `tx_drive`. Whenever both low status bits rise together the driver is already disabled. A timeout bit that rises on its own is always preceded by at least the full window of idle line ticks.

Other behaviour is shown only by the bench's scenarios, because it depends on what the response contains. These are the CRC, end-bit and index decisions, the exact tick at which the window closes and the start bit accepted on the last tick of the window. The same holds for commands that expect no response and for the priority of a new error over a clear in the same cycle.

// File: rtl/sd_cmd_err_pkg.sv
package sd_cmd_err_pkg;
  localparam int ERR_TMO = 0;
  localparam int ERR_CRC = 1;
  localparam int ERR_END = 2;
  localparam int ERR_IDX = 3;
  localparam int NUM_ERR = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_WAIT = 2'd2,
    ST_RX   = 2'd3
  } cmd_state_e;
endpackage

// File: rtl/sd_crc7_ser.sv
module sd_crc7_ser #(
  parameter int          W    = 7,
  parameter logic [W-1:0] POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         restart,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] base;
  logic         fb;

  assign base = restart ? '0 : crc;
  assign fb   = din ^ base[W-1];

  always_ff @(posedge clk) begin
    if (rst) crc <= '0;
    else if (en) crc <= {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/sd_cmd_conflict.sv
module sd_cmd_conflict (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tx_drive,
  input  logic tx_bit,
  input  logic cmd_line,
  output logic conflict,
  output logic abort
);
  logic drove_one;

  // the 1 driven on the previous tick must be read back on this one
  assign conflict = tick & tx_drive & drove_one & ~cmd_line & ~abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      drove_one <= 1'b0;
      abort     <= 1'b0;
    end else begin
      if (tick) drove_one <= tx_drive & tx_bit & ~abort;
      if (conflict)      abort <= 1'b1;
      else if (!tx_drive) abort <= 1'b0;
    end
  end
endmodule

// File: rtl/sd_cmd_status.sv
module sd_cmd_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status
);
  logic [N-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_eff) | set_ev;
  end
endmodule

// File: rtl/sd_cmd_err_det.sv
module sd_cmd_err_det
  import sd_cmd_err_pkg::*;
#(
  parameter int TMO_TICKS = 64,
  parameter int RESP_LEN  = 48,
  parameter int IDX_W     = 6,
  parameter int CRC_W     = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sd_tick,
  input  logic               tx_drive,
  input  logic               tx_bit,
  input  logic               cmd_line,
  input  logic [IDX_W-1:0]   cmd_index,
  input  logic               resp_expected,
  input  logic               clr_we,
  input  logic [NUM_ERR-1:0] clr_mask,
  output logic [NUM_ERR-1:0] status,
  output logic               cmd_oe
);
  localparam int CNT_W  = $clog2(TMO_TICKS);
  localparam int BC_W   = $clog2(RESP_LEN + 1);
  localparam int SH_W   = RESP_LEN - 2;
  localparam int IDX_HI = SH_W - 2;
  localparam int IDX_LO = SH_W - 1 - IDX_W;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(TMO_TICKS - 1);
  localparam logic [BC_W-1:0]  BC_CRCEND = BC_W'(RESP_LEN - CRC_W - 1);
  localparam logic [BC_W-1:0]  BC_SHEND  = BC_W'(RESP_LEN - 2);
  localparam logic [BC_W-1:0]  BC_LAST   = BC_W'(RESP_LEN - 1);

  cmd_state_e         st;
  logic [CNT_W-1:0]   wait_cnt;
  logic [BC_W-1:0]    bit_cnt;
  logic [SH_W-1:0]    shreg;
  logic [IDX_W-1:0]   idx_q;
  logic               rexp_q;
  logic [CRC_W-1:0]   crc;
  logic               conflict, abort;
  logic               start_seen, crc_en, last_bit;
  logic [NUM_ERR-1:0] set_ev;

  sd_cmd_conflict u_conf (
    .clk(clk), .rst(rst), .tick(sd_tick), .tx_drive(tx_drive),
    .tx_bit(tx_bit), .cmd_line(cmd_line), .conflict(conflict), .abort(abort)
  );

  assign cmd_oe = tx_drive & ~abort;

  assign start_seen = sd_tick && st == ST_WAIT && !cmd_line;
  assign crc_en     = start_seen || (sd_tick && st == ST_RX && bit_cnt < BC_CRCEND);
  assign last_bit   = sd_tick && st == ST_RX && bit_cnt == BC_LAST;

  sd_crc7_ser #(.W(CRC_W)) u_crc (
    .clk(clk), .rst(rst), .en(crc_en), .restart(st == ST_WAIT),
    .din(cmd_line), .crc(crc)
  );

  always_comb begin
    set_ev = '0;
    if (conflict) begin
      set_ev[ERR_TMO] = 1'b1;
      set_ev[ERR_CRC] = 1'b1;
    end
    if (sd_tick && st == ST_WAIT && cmd_line && wait_cnt == CNT_LAST)
      set_ev[ERR_TMO] = 1'b1;
    if (last_bit) begin
      if (shreg[CRC_W-1:0] != crc)         set_ev[ERR_CRC] = 1'b1;
      if (!cmd_line)                       set_ev[ERR_END] = 1'b1;
      if (shreg[IDX_HI:IDX_LO] != idx_q)   set_ev[ERR_IDX] = 1'b1;
    end
  end

  sd_cmd_status #(.N(NUM_ERR)) u_stat (
    .clk(clk), .rst(rst), .set_ev(set_ev), .clr_we(clr_we),
    .clr_mask(clr_mask), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      wait_cnt <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
      idx_q    <= '0;
      rexp_q   <= 1'b0;
    end else if (sd_tick) begin
      unique case (st)
        ST_IDLE: if (tx_drive) begin
          st     <= ST_TX;
          idx_q  <= cmd_index;
          rexp_q <= resp_expected;
        end
        ST_TX: if (!tx_drive) begin
          st       <= (rexp_q && !abort) ? ST_WAIT : ST_IDLE;
          wait_cnt <= '0;
        end
        ST_WAIT: begin
          if (!cmd_line) begin
            st      <= ST_RX;
            bit_cnt <= BC_W'(1);
          end else if (wait_cnt == CNT_LAST) begin
            st <= ST_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_RX: begin
          if (bit_cnt <= BC_SHEND) shreg <= {shreg[SH_W-2:0], cmd_line};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BC_LAST) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_err_chk.sv
module sd_cmd_err_chk #(
  parameter int TMO_TICKS = 64,
  parameter int N         = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         sd_tick,
  input logic         tx_drive,
  input logic         cmd_line,
  input logic         clr_we,
  input logic [N-1:0] clr_mask,
  input logic [N-1:0] status,
  input logic         cmd_oe
);
  int quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst) quiet_cnt <= 0;
    else if (sd_tick) begin
      if (tx_drive || !cmd_line) quiet_cnt <= 0;
      else if (quiet_cnt < TMO_TICKS + 4) quiet_cnt <= quiet_cnt + 1;
    end
  end

  // R12
  oe_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_drive |-> !cmd_oe);

  // R5
  oe_abort_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0] & status[1]) |-> !cmd_oe);

  // R4
  tmo_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> (quiet_cnt >= TMO_TICKS) || status[1]);

  for (genvar i = 0; i < N; i++) begin : g_hold
    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
      status[i] && !(clr_we && clr_mask[i]) |=> status[i]);
  end
endmodule

bind sd_cmd_err_det sd_cmd_err_chk #(.TMO_TICKS(TMO_TICKS), .N(4)) u_chk (
  .clk(clk), .rst(rst), .sd_tick(sd_tick), .tx_drive(tx_drive),
  .cmd_line(cmd_line), .clr_we(clr_we), .clr_mask(clr_mask),
  .status(status), .cmd_oe(cmd_oe)
);

// File: tb/test_sd_cmd_err_det.sv
module test_sd_cmd_err_det;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, sd_tick, tx_drive, tx_bit, cmd_line, resp_expected, clr_we;
  logic [5:0] cmd_index;
  logic [3:0] clr_mask, status;
  logic       cmd_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  typedef struct { logic [3:0] st; string tag; } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_err_det i_sd_cmd_err_det (
    .clk(clk), .rst(rst), .sd_tick(sd_tick), .tx_drive(tx_drive),
    .tx_bit(tx_bit), .cmd_line(cmd_line), .cmd_index(cmd_index),
    .resp_expected(resp_expected), .clr_we(clr_we), .clr_mask(clr_mask),
    .status(status), .cmd_oe(cmd_oe)
  );

  function automatic logic [6:0] crc_of(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  // monitor: pops expected status and compares with the design
  initial forever begin
    exp_t e;
    @(chk_ev);
    e = exp_q.pop_front();
    n_checks++;
    if (status !== e.st) begin
      n_errors++;
      $display("FAIL %s: status=%b expected=%b", e.tag, status, e.st);
    end
  end

  task automatic expect_status(input logic [3:0] v, input string tag);
    exp_q.push_back('{st: v, tag: tag});
    -> chk_ev;
    #1;
  endtask

  task automatic check_oe(input logic v, input string tag);
    n_checks++;
    if (cmd_oe !== v) begin
      n_errors++;
      $display("FAIL %s: cmd_oe=%b expected=%b", tag, cmd_oe, v);
    end
  endtask

  task automatic do_tick(input logic drv, input logic b, input logic line);
    tx_drive = drv; tx_bit = b; cmd_line = line; sd_tick = 1'b1;
    @(posedge clk); #1;
    sd_tick = 1'b0; clr_we = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_tick(1'b0, 1'b1, 1'b1);
  endtask

  task automatic write_clr(input logic [3:0] m);
    clr_we = 1'b1; clr_mask = m;
    @(posedge clk); #1;
    clr_we = 1'b0;
  endtask

  task automatic send_cmd(input logic [5:0] idx, input logic rexp, input int conf_at);
    logic [47:0] f;
    logic prev = 1'b1;
    f[47:8] = {1'b0, 1'b1, idx, 32'h1234_ABCD};
    f[7:0]  = {crc_of(f[47:8]), 1'b1};
    cmd_index = idx; resp_expected = rexp;
    for (int i = 0; i < 48; i++) begin
      do_tick(1'b1, f[47-i], (i == conf_at) ? 1'b0 : prev);
      if (conf_at < 0 && i == 5) check_oe(1'b1, "R12 oe follows drive");
      if (i == conf_at) begin
        expect_status(4'b0011, "R6 conflict flags immediate");
        check_oe(1'b0, "R5 oe dropped on conflict");
      end
      if (conf_at >= 0 && i == conf_at + 3) check_oe(1'b0, "R5 oe stays low");
      prev = cmd_oe ? f[47-i] : 1'b1;
    end
    do_tick(1'b0, 1'b1, prev);
  endtask

  task automatic send_resp(input logic [5:0] idx, input logic [6:0] bad, input logic endb);
    logic [47:0] f;
    f[47:8] = {1'b0, 1'b0, idx, 32'h0000_0900};
    f[7:0]  = {crc_of(f[47:8]) ^ bad, endb};
    for (int i = 0; i < 48; i++) do_tick(1'b0, 1'b1, f[47-i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sd_tick = 0; tx_drive = 0; tx_bit = 1; cmd_line = 1;
    cmd_index = '0; resp_expected = 0; clr_we = 0; clr_mask = '0;
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #1;
    expect_status(4'b0000, "R1 reset status");
    check_oe(1'b0, "R1 reset oe");

    // R10: correct response
    send_cmd(6'd17, 1'b1, -1); idle(10); send_resp(6'd17, 7'h00, 1'b1);
    expect_status(4'b0000, "R10 good response");

    // R7: bad CRC, then R2 clear
    send_cmd(6'd5, 1'b1, -1); idle(3); send_resp(6'd5, 7'h01, 1'b1);
    expect_status(4'b0010, "R7 crc error only");
    write_clr(4'b0010);
    expect_status(4'b0000, "R2 clear crc bit");

    // R8: end bit 0; R2 mask 0 no effect
    send_cmd(6'd8, 1'b1, -1); idle(2); send_resp(6'd8, 7'h00, 1'b0);
    expect_status(4'b0100, "R8 end bit error");
    write_clr(4'b0000);
    expect_status(4'b0100, "R2 zero mask keeps bit");
    write_clr(4'b1111);
    expect_status(4'b0000, "R2 clear all");

    // R9: index mismatch
    send_cmd(6'd12, 1'b1, -1); idle(1); send_resp(6'd13, 7'h00, 1'b1);
    expect_status(4'b1000, "R9 index mismatch");
    write_clr(4'b1000);

    // R4: timeout window
    send_cmd(6'd3, 1'b1, -1); idle(63);
    expect_status(4'b0000, "R4 no timeout at tick 63");
    idle(1);
    expect_status(4'b0001, "R4 timeout at tick 64");
    write_clr(4'b0001);

    // R4: start bit on the last window tick accepted
    send_cmd(6'd3, 1'b1, -1); idle(63); send_resp(6'd3, 7'h00, 1'b1);
    expect_status(4'b0000, "R4 start on tick 64 accepted");

    // R5/R6: line conflict at the third bit
    send_cmd(6'd9, 1'b1, 2);
    expect_status(4'b0011, "R6 conflict after release");
    idle(70);
    expect_status(4'b0011, "R6 no response wait after conflict");
    write_clr(4'b0011);
    expect_status(4'b0000, "R2 clear conflict");

    // R11: no response expected
    send_cmd(6'd4, 1'b0, -1); idle(80); send_resp(6'd7, 7'h05, 1'b0);
    expect_status(4'b0000, "R11 no checks without response");

    // R3: clear and timeout in the same cycle
    send_cmd(6'd3, 1'b1, -1); idle(63);
    clr_we = 1'b1; clr_mask = 4'b0001;
    do_tick(1'b0, 1'b1, 1'b1);
    expect_status(4'b0001, "R3 set wins over clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule